// File: doc/BRIEF.md
# Cache Line State Policy Controller

This block holds the coherence state (invalid, shared, exclusive, modified) of a small direct-mapped set of data-cache lines. It watches a simplified burst bus and decides which state a line enters. A cacheable read miss fills the line. A hit write cycle to a shared line updates it. In both cases the decision comes from a writeback-policy input and the page's write-through attribute. The policy input is captured only once per bus cycle, on the first ready or next-address strobe, and only for cycle types that qualify.

Core write hits are reported separately. A hit on an exclusive line makes it modified. A hit on a shared line requests an external write cycle, and that cycle's completion then sets the line's new state. Snoops and flush commands produce writeback requests for modified lines, handshaked one at a time. Line contents, tag comparison and the bus master sit outside the block. Hit/miss and the line index arrive as inputs. Any line's state can be read through a registered read port.

Top module: `cache_state_ctrl`

## Requirements
- R1: After a synchronous reset every line reads as invalid, and `ext_wr`, `wb_req` and `done` are low. State codes on `st_out` are 0 invalid, 1 shared, 2 exclusive, 3 modified. `st_out` shows the state of line `st_idx` as it was before the clock edge that loads it.
- R2: When a cacheable memory-read cycle (type 0) that missed completes, its line becomes exclusive if the captured policy is 1 and the write-through bit is 0, and shared otherwise. A fill never changes a line that is modified.
- R3: A core write hit to an exclusive line makes it modified. A write hit to a modified line leaves it modified. Neither raises `ext_wr`.
- R4: A core write hit to a shared line raises `ext_wr` for one cycle on the next cycle, with `ext_idx` set to the line, and leaves the state unchanged. When a hit memory-write cycle (type 1) to a shared line completes, the line takes the state given by the rule of R2.
- R5: The policy input is captured on the first cycle of a bus cycle in which ready or next-address is high. Later values in the same cycle have no effect.
- R6: A cacheable memory read is a burst and completes on its fourth ready. Every other cycle completes on its first ready. Idle cycles between ready strobes are allowed.
- R7: Writeback-write cycles (type 2) and other cycles (type 3) leave all line states unchanged whatever the policy input. A cycle-start strobe arriving while a cycle is in progress is ignored.
- R8: A snoop to a non-modified line invalidates it on the next edge. A snoop to a modified line holds `wb_req` high with `wb_idx` set to the line until `wb_ack` is seen, and then invalidates the line.
- R9: A flush scans the lines in ascending index order and issues one acknowledged writeback per modified line. It then invalidates every line at once and pulses `done` for one cycle.
- R10: While a snoop writeback or a flush is in progress, core write hits, snoops and flush commands are ignored.
- R11: A snoop and a core write hit to the same line in the same cycle: the snoop wins, and the write hit causes neither `ext_wr` nor a state change. A write hit to a line whose bus cycle completes in that same cycle is dropped, and the fill decides the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | Bus cycle start strobe |
| cyc_type | input | 2 | Cycle type: 0 mem read, 1 mem write, 2 writeback write, 3 other |
| cyc_idx | input | IDX_W | Line index of the bus cycle |
| cyc_cache | input | 1 | Cycle is cacheable |
| cyc_hit | input | 1 | Cycle address hit the cache |
| cyc_pwt | input | 1 | Page write-through attribute |
| xfer_rdy | input | 1 | Transfer ready strobe |
| nxt_addr | input | 1 | Next-address strobe |
| wb_policy | input | 1 | Policy: 1 writeback allowed, 0 write-through |
| wr_valid | input | 1 | Core write request |
| wr_hit | input | 1 | Core write hit |
| wr_idx | input | IDX_W | Core write line index |
| snp_valid | input | 1 | Snoop request |
| snp_idx | input | IDX_W | Snoop line index |
| flush | input | 1 | Flush / writeback-invalidate command |
| wb_ack | input | 1 | Writeback accepted |
| st_idx | input | IDX_W | State read index |
| st_out | output | 2 | Registered state of line st_idx |
| ext_wr | output | 1 | External write cycle request for a shared-line hit |
| ext_idx | output | IDX_W | Line of the external write |
| wb_req | output | 1 | Writeback request |
| wb_idx | output | IDX_W | Line to write back |
| done | output | 1 | Flush finished pulse |

## Verification
Two functions can collide in one cycle. A snoop and a core write hit can name the same line, and a read fill can complete on the same edge as a write hit to its line. The bench provokes the first by driving both requests together on an exclusive line. It provokes the second by raising a write hit during the final ready beat of a burst. A behavioural model keeps its own line states and judges both cases on every clock: the line must end invalid, or in the fill's state, and no external write may appear.

// File: rtl/cls_pkg.sv
package cls_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2,
    LS_MOD = 2'd3
  } line_st_t;

  localparam logic [1:0] CT_MRD = 2'd0;
  localparam logic [1:0] CT_MWR = 2'd1;
endpackage

// File: rtl/cls_bus_mon.sv
module cls_bus_mon
  import cls_pkg::*;
#(
  parameter int IDX_W     = 3,
  parameter int BURST_LEN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_start,
  input  logic [1:0]       cyc_type,
  input  logic [IDX_W-1:0] cyc_idx,
  input  logic             cyc_cache,
  input  logic             cyc_hit,
  input  logic             cyc_pwt,
  input  logic             xfer_rdy,
  input  logic             nxt_addr,
  input  logic             wb_policy,
  output logic             fill_v,
  output logic             fill_rd,
  output logic [IDX_W-1:0] fill_idx,
  output logic             fill_excl
);
  localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

  logic             act, smp, polq, bcache, bhit, bpwt;
  logic [1:0]       btype;
  logic [IDX_W-1:0] bidx;
  logic [BEAT_W-1:0] beat;
  logic             qual, burst, fin, pol_now;

  assign qual    = (btype == CT_MRD) || (btype == CT_MWR);
  assign burst   = (btype == CT_MRD) && bcache;
  assign fin     = act && xfer_rdy && (!burst || beat == BEAT_W'(BURST_LEN - 1));
  assign pol_now = smp ? polq : wb_policy;

  assign fill_v    = fin && qual &&
                     ((burst && !bhit) || (btype == CT_MWR && bhit));
  assign fill_rd   = (btype == CT_MRD);
  assign fill_idx  = bidx;
  assign fill_excl = pol_now && !bpwt;

  always_ff @(posedge clk) begin
    if (rst) begin
      act <= 1'b0; smp <= 1'b0; polq <= 1'b0; beat <= '0;
      btype <= '0; bidx <= '0; bcache <= 1'b0; bhit <= 1'b0; bpwt <= 1'b0;
    end else if (!act) begin
      if (cyc_start) begin
        act <= 1'b1; smp <= 1'b0; beat <= '0;
        btype <= cyc_type; bidx <= cyc_idx;
        bcache <= cyc_cache; bhit <= cyc_hit; bpwt <= cyc_pwt;
      end
    end else begin
      if (fin) act <= 1'b0;
      if ((xfer_rdy || nxt_addr) && !smp && qual) begin
        smp  <= 1'b1;
        polq <= wb_policy;
      end
      if (xfer_rdy) beat <= beat + 1'b1;
    end
  end

  // R5: once captured, the policy stays put for the rest of the cycle
  p_pol_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (act && smp && !fin) |=> $stable(polq));
endmodule

// File: rtl/cls_wb_seq.sv
module cls_wb_seq
  import cls_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  line_st_t [(1<<IDX_W)-1:0]   lines_i,
  input  logic                        snp_valid,
  input  logic [IDX_W-1:0]            snp_idx,
  input  logic                        flush,
  input  logic                        wb_ack,
  output logic                        wb_req,
  output logic [IDX_W-1:0]            wb_idx,
  output logic                        done,
  output logic                        idle,
  output logic                        inv_v,
  output logic [IDX_W-1:0]            inv_idx,
  output logic                        clr_all
);
  localparam int NLINES = 1 << IDX_W;

  typedef enum logic [1:0] {Q_IDLE, Q_SWB, Q_SCAN, Q_FWB} seq_t;
  seq_t             q;
  logic [IDX_W-1:0] ptr;
  logic             ptr_last;

  assign idle     = (q == Q_IDLE);
  assign ptr_last = (ptr == IDX_W'(NLINES - 1));

  always_comb begin
    inv_v   = 1'b0;
    inv_idx = snp_idx;
    clr_all = 1'b0;
    case (q)
      Q_IDLE: inv_v = snp_valid && (lines_i[snp_idx] != LS_MOD);
      Q_SWB:  begin inv_v = wb_ack; inv_idx = wb_idx; end
      Q_SCAN: clr_all = (lines_i[ptr] != LS_MOD) && ptr_last;
      Q_FWB:  clr_all = wb_ack && ptr_last;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= Q_IDLE; ptr <= '0; wb_req <= 1'b0; wb_idx <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (q)
        Q_IDLE: begin
          if (snp_valid) begin
            if (lines_i[snp_idx] == LS_MOD) begin
              wb_req <= 1'b1; wb_idx <= snp_idx; q <= Q_SWB;
            end
          end else if (flush) begin
            ptr <= '0; q <= Q_SCAN;
          end
        end
        Q_SWB: if (wb_ack) begin wb_req <= 1'b0; q <= Q_IDLE; end
        Q_SCAN: begin
          if (lines_i[ptr] == LS_MOD) begin
            wb_req <= 1'b1; wb_idx <= ptr; q <= Q_FWB;
          end else if (ptr_last) begin
            done <= 1'b1; q <= Q_IDLE;
          end else ptr <= ptr + 1'b1;
        end
        Q_FWB: if (wb_ack) begin
          wb_req <= 1'b0;
          if (ptr_last) begin done <= 1'b1; q <= Q_IDLE; end
          else begin ptr <= ptr + 1'b1; q <= Q_SCAN; end
        end
        default: q <= Q_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cache_state_ctrl.sv
module cache_state_ctrl
  import cls_pkg::*;
#(
  parameter int IDX_W     = 3,
  parameter int BURST_LEN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_start,
  input  logic [1:0]       cyc_type,
  input  logic [IDX_W-1:0] cyc_idx,
  input  logic             cyc_cache,
  input  logic             cyc_hit,
  input  logic             cyc_pwt,
  input  logic             xfer_rdy,
  input  logic             nxt_addr,
  input  logic             wb_policy,
  input  logic             wr_valid,
  input  logic             wr_hit,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             snp_valid,
  input  logic [IDX_W-1:0] snp_idx,
  input  logic             flush,
  input  logic             wb_ack,
  input  logic [IDX_W-1:0] st_idx,
  output logic [1:0]       st_out,
  output logic             ext_wr,
  output logic [IDX_W-1:0] ext_idx,
  output logic             wb_req,
  output logic [IDX_W-1:0] wb_idx,
  output logic             done
);
  localparam int NLINES = 1 << IDX_W;

  line_st_t [NLINES-1:0] lines;

  logic             fill_v, fill_rd, fill_excl, fill_ok;
  logic [IDX_W-1:0] fill_idx, inv_idx;
  logic             wb_idle, inv_v, clr_all, wh;
  line_st_t         fill_new;

  cls_bus_mon #(.IDX_W(IDX_W), .BURST_LEN(BURST_LEN)) u_mon (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .cyc_type(cyc_type),
    .cyc_idx(cyc_idx), .cyc_cache(cyc_cache), .cyc_hit(cyc_hit),
    .cyc_pwt(cyc_pwt), .xfer_rdy(xfer_rdy), .nxt_addr(nxt_addr),
    .wb_policy(wb_policy), .fill_v(fill_v), .fill_rd(fill_rd),
    .fill_idx(fill_idx), .fill_excl(fill_excl)
  );

  cls_wb_seq #(.IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst(rst), .lines_i(lines), .snp_valid(snp_valid),
    .snp_idx(snp_idx), .flush(flush), .wb_ack(wb_ack), .wb_req(wb_req),
    .wb_idx(wb_idx), .done(done), .idle(wb_idle), .inv_v(inv_v),
    .inv_idx(inv_idx), .clr_all(clr_all)
  );

  assign fill_new = fill_excl ? LS_EXC : LS_SHR;
  assign fill_ok  = fill_v && (fill_rd ? (lines[fill_idx] != LS_MOD)
                                       : (lines[fill_idx] == LS_SHR));
  assign wh = wr_valid && wr_hit && wb_idle &&
              !(snp_valid && snp_idx == wr_idx) &&
              !(fill_v && fill_idx == wr_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      lines   <= {NLINES{LS_INV}};
      st_out  <= '0;
      ext_wr  <= 1'b0;
      ext_idx <= '0;
    end else begin
      st_out  <= lines[st_idx];
      ext_wr  <= wh && (lines[wr_idx] == LS_SHR);
      ext_idx <= wr_idx;
      for (int i = 0; i < NLINES; i++) begin
        if (clr_all)
          lines[i] <= LS_INV;
        else if (inv_v && inv_idx == IDX_W'(i))
          lines[i] <= LS_INV;
        else if (fill_ok && fill_idx == IDX_W'(i))
          lines[i] <= fill_new;
        else if (wh && wr_idx == IDX_W'(i) && lines[i] == LS_EXC)
          lines[i] <= LS_MOD;
      end
    end
  end

  // R1: first read after reset returns invalid
  p_reset_inv_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |=> (st_out == LS_INV));
  // R3: accepted write hit on an exclusive line yields modified
  p_exc_mod_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_hit && wb_idle && !snp_valid && !fill_v &&
     lines[wr_idx] == LS_EXC) |=> (lines[$past(wr_idx)] == LS_MOD));
  // R4: an external write is only requested for a shared line
  p_ext_shr_r4: assert property (@(posedge clk) disable iff (rst)
    ext_wr |-> (lines[ext_idx] == LS_SHR));
  // R8: writeback requests only name modified lines
  p_wb_mod_r8: assert property (@(posedge clk) disable iff (rst)
    wb_req |-> (lines[wb_idx] == LS_MOD));
  // R9: flush completion leaves every line invalid
  p_done_clear_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (lines == {NLINES{LS_INV}}));
  // R10: busy sequencer blocks core write hits
  p_busy_nowr_r10: assert property (@(posedge clk) disable iff (rst)
    (!wb_idle && wr_valid && wr_hit) |=> !ext_wr);
endmodule

// File: tb/sim_cache_state_ctrl.sv
`timescale 1ns/1ps
module sim_cache_state_ctrl;
  localparam int IW = 3;
  localparam int NL = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_start = 0, cyc_cache = 0, cyc_hit = 0, cyc_pwt = 0;
  logic [1:0] cyc_type = 0;
  logic [IW-1:0] cyc_idx = 0, wr_idx = 0, snp_idx = 0, st_idx = 0;
  logic xfer_rdy = 0, nxt_addr = 0, wb_policy = 0;
  logic wr_valid = 0, wr_hit = 0, snp_valid = 0, flush = 0, wb_ack = 0;
  logic [1:0] st_out;
  logic ext_wr, wb_req, done;
  logic [IW-1:0] ext_idx, wb_idx;

  always #4 clk = ~clk;  // 125 MHz

  cache_state_ctrl u0 (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .cyc_type(cyc_type),
    .cyc_idx(cyc_idx), .cyc_cache(cyc_cache), .cyc_hit(cyc_hit),
    .cyc_pwt(cyc_pwt), .xfer_rdy(xfer_rdy), .nxt_addr(nxt_addr),
    .wb_policy(wb_policy), .wr_valid(wr_valid), .wr_hit(wr_hit),
    .wr_idx(wr_idx), .snp_valid(snp_valid), .snp_idx(snp_idx),
    .flush(flush), .wb_ack(wb_ack), .st_idx(st_idx), .st_out(st_out),
    .ext_wr(ext_wr), .ext_idx(ext_idx), .wb_req(wb_req),
    .wb_idx(wb_idx), .done(done)
  );

  int checks = 0, errors = 0;
  string cur_req = "R1";

  // behavioural reference model
  int m_ln [NL];
  int b_act, b_type, b_idx, b_cache, b_hit, b_pwt, b_beat, b_smp, b_pol;
  int mq, mptr, m_wbr, m_wbi;
  int e_st, e_ext, e_exti, e_wbr, e_wbi, e_done;
  bit chk_on = 0;

  always @(posedge clk) st_idx <= #1 st_idx + 1'b1;

  always @(posedge clk) begin
    int qual, burst, fin, polv, fv, fok, fnew, inv, invi, clr, nd, wh, old_wr;
    if (rst) begin
      foreach (m_ln[i]) m_ln[i] = 0;
      b_act = 0; b_smp = 0; b_beat = 0; b_pol = 0; b_type = 0; b_idx = 0;
      b_cache = 0; b_hit = 0; b_pwt = 0;
      mq = 0; mptr = 0; m_wbr = 0; m_wbi = 0;
      e_st = 0; e_ext = 0; e_exti = 0; e_wbr = 0; e_wbi = 0; e_done = 0;
    end else begin
      qual  = (b_type <= 1);
      burst = (b_type == 0) && b_cache;
      fin   = b_act && xfer_rdy && (!burst || b_beat == 3);
      polv  = b_smp ? b_pol : wb_policy;
      fv    = fin && qual && ((burst && !b_hit) || (b_type == 1 && b_hit));
      fok   = fv && ((b_type == 0) ? (m_ln[b_idx] != 3) : (m_ln[b_idx] == 1));
      fnew  = (polv && !b_pwt) ? 2 : 1;
      inv = 0; invi = 0; clr = 0; nd = 0;
      wh = wr_valid && wr_hit && (mq == 0) &&
           !(snp_valid && snp_idx == wr_idx) && !(fv && b_idx == wr_idx);
      old_wr = m_ln[wr_idx];
      case (mq)
        0: if (snp_valid) begin
             if (m_ln[snp_idx] == 3) begin m_wbr = 1; m_wbi = snp_idx; mq = 1; end
             else begin inv = 1; invi = snp_idx; end
           end else if (flush) begin mptr = 0; mq = 2; end
        1: if (wb_ack) begin m_wbr = 0; inv = 1; invi = m_wbi; mq = 0; end
        2: if (m_ln[mptr] == 3) begin m_wbr = 1; m_wbi = mptr; mq = 3; end
           else if (mptr == NL-1) begin clr = 1; nd = 1; mq = 0; end
           else mptr++;
        default: if (wb_ack) begin
             m_wbr = 0;
             if (mptr == NL-1) begin clr = 1; nd = 1; mq = 0; end
             else begin mptr++; mq = 2; end
           end
      endcase
      e_st   = m_ln[st_idx];
      e_ext  = wh && (old_wr == 1);
      e_exti = wr_idx;
      for (int i = 0; i < NL; i++) begin
        if (clr) m_ln[i] = 0;
        else if (inv && invi == i) m_ln[i] = 0;
        else if (fok && b_idx == i) m_ln[i] = fnew;
        else if (wh && wr_idx == i && old_wr == 2) m_ln[i] = 3;
      end
      if (!b_act) begin
        if (cyc_start) begin
          b_act = 1; b_smp = 0; b_beat = 0; b_type = cyc_type; b_idx = cyc_idx;
          b_cache = cyc_cache; b_hit = cyc_hit; b_pwt = cyc_pwt;
        end
      end else begin
        if ((xfer_rdy || nxt_addr) && !b_smp && qual) begin b_smp = 1; b_pol = wb_policy; end
        if (xfer_rdy) b_beat = (b_beat + 1) % 4;
        if (fin) b_act = 0;
      end
      e_wbr = m_wbr; e_wbi = m_wbi; e_done = nd;
    end
    chk_on = 1;
  end

  task automatic chk(input string nm, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", cur_req, nm, act, exp);
    end
  endtask

  always @(negedge clk) if (chk_on) begin
    chk("st_out", st_out, e_st);
    chk("ext_wr", ext_wr, e_ext);
    if (e_ext) chk("ext_idx", ext_idx, e_exti);
    chk("wb_req", wb_req, e_wbr);
    if (e_wbr) chk("wb_idx", wb_idx, e_wbi);
    chk("done", done, e_done);
  end

  task automatic step(); @(posedge clk); #2; endtask

  task automatic bus_cycle(input int ty, input int idx, input bit ca, input bit hi,
                           input bit pwt, input int beats, input bit p_first,
                           input bit p_rest, input bit use_na, input bit wh_last);
    cyc_start = 1; cyc_type = ty[1:0]; cyc_idx = idx[IW-1:0];
    cyc_cache = ca; cyc_hit = hi; cyc_pwt = pwt; wb_policy = !p_first;
    step(); cyc_start = 0;
    if (use_na) begin nxt_addr = 1; wb_policy = p_first; step(); nxt_addr = 0; end
    for (int k = 0; k < beats; k++) begin
      xfer_rdy = 1;
      wb_policy = (k == 0 && !use_na) ? p_first : p_rest;
      if (wh_last && k == beats - 1) begin
        wr_valid = 1; wr_hit = 1; wr_idx = idx[IW-1:0];
      end
      step(); xfer_rdy = 0; wr_valid = 0;
      if (k == 1) step();  // gap between beats
    end
    step();
  endtask

  task automatic wr(input int idx);
    wr_valid = 1; wr_hit = 1; wr_idx = idx[IW-1:0]; step(); wr_valid = 0; step();
  endtask

  task automatic snoop(input int idx);
    snp_valid = 1; snp_idx = idx[IW-1:0]; step(); snp_valid = 0; step();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL %s watchdog actual=1 expected=0", cur_req);
    summary(); $finish;
  end

  initial begin
    repeat (4) step();
    rst = 0;
    cur_req = "R1"; repeat (10) step();
    cur_req = "R2";  // burst read misses: EXC, SHR, SHR (pwt)
    bus_cycle(0, 1, 1, 0, 0, 4, 1, 1, 0, 0);
    bus_cycle(0, 2, 1, 0, 0, 4, 0, 0, 0, 0);
    bus_cycle(0, 3, 1, 0, 1, 4, 1, 1, 0, 0);
    repeat (8) step();
    cur_req = "R3";
    wr(1); wr(1); repeat (8) step();
    cur_req = "R2";  // fill must not touch a modified line
    bus_cycle(0, 1, 1, 0, 0, 4, 0, 0, 0, 0); repeat (8) step();
    cur_req = "R4";
    wr(2); wr(3);
    bus_cycle(1, 2, 1, 1, 0, 1, 1, 1, 0, 0);
    bus_cycle(1, 3, 1, 1, 1, 1, 1, 1, 1, 0);
    repeat (8) step();
    cur_req = "R5";  // next-address capture then opposite policy on ready
    bus_cycle(0, 4, 1, 0, 0, 4, 1, 0, 1, 0);
    bus_cycle(0, 5, 1, 0, 0, 4, 0, 1, 0, 0);
    repeat (8) step();
    cur_req = "R6";  // non-cacheable read finishes on one ready
    bus_cycle(0, 6, 0, 0, 0, 1, 1, 1, 0, 0);
    bus_cycle(0, 6, 1, 0, 0, 4, 1, 0, 0, 0);
    repeat (8) step();
    cur_req = "R7";
    bus_cycle(2, 2, 1, 1, 0, 1, 0, 0, 0, 0);
    bus_cycle(3, 5, 1, 0, 0, 1, 1, 1, 0, 0);
    cyc_start = 1; cyc_type = 0; cyc_idx = 7; cyc_cache = 1; cyc_hit = 0; step();
    cyc_start = 1; cyc_idx = 0; wb_policy = 1; step(); cyc_start = 0;
    for (int k = 0; k < 4; k++) begin xfer_rdy = 1; step(); xfer_rdy = 0; step(); end
    repeat (8) step();
    cur_req = "R8";
    snoop(5); snp_valid = 1; snp_idx = 1; step(); snp_valid = 0;
    repeat (3) step();
    cur_req = "R10";
    wr(4); snoop(2); flush = 1; step(); flush = 0;
    wb_ack = 1; step(); wb_ack = 0; repeat (8) step();
    cur_req = "R11";
    snp_valid = 1; snp_idx = 4; wr_valid = 1; wr_hit = 1; wr_idx = 4;
    step(); snp_valid = 0; wr_valid = 0; repeat (4) step();
    bus_cycle(0, 6, 1, 0, 0, 4, 0, 0, 0, 1);
    repeat (8) step();
    cur_req = "R9";
    bus_cycle(0, 0, 1, 0, 0, 4, 1, 1, 0, 0);
    bus_cycle(0, 4, 1, 0, 0, 4, 1, 1, 0, 0);
    bus_cycle(0, 7, 1, 0, 0, 4, 1, 1, 0, 0);
    wr(0); wr(4); wr(7); wr(6);
    flush = 1; step(); flush = 0;
    for (int k = 0; k < 80; k++) begin
      wb_ack = (wb_req && !wb_ack && (k % 3 == 0));
      step();
    end
    wb_ack = 0; repeat (10) step();
    summary(); $finish;
  end
endmodule